// File: doc/BRIEF.md
# Scan Test Sequencer and Comparator

This block is a small on-chip scan tester. It drives a four-cell mux-D scan chain built around a 4-bit incrementing counter. It generates scan-enable and a serial scan-in bit, and it samples the serial scan-out bit. A counter under test is included in the block. Its shift path runs from scan-in through count bit 0, then bits 1, 2 and 3, and out to scan-out. Two fault injection inputs let the block check itself: one holds the increment carry at 0, the other cuts one shift link in the chain.

After a start request, the sequencer first runs a flush test on the chain. It shifts the word 0011 in, then shifts zeros, and checks that the word comes out intact four clocks later. If the flush fails, the block reports a broken chain and applies no capture pattern. If the flush passes, the block runs one load, capture and unload cycle. It loads the stimulus most significant bit first, applies a single functional clock, and unloads the captured word. It then compares that word with the golden word and reports pass or fail. The captured word is also made available for diagnosis.

Top module: `scan_test_ctrl`

## Requirements
- R1: In shift mode (scan_en_o high) each chain cell takes the previous cell's value. Count bit 0 takes scan_in_o, and scan_out_o is count bit 3.
- R2: With scan_en_o low, the counter adds one with a ripple carry and wraps from 1111 to 0000.
- R3: A run that passes the flush holds scan_en_o high for 8 flush clocks and 4 load clocks. It then holds scan_en_o low for exactly one capture clock, then high for 4 unload clocks. done_o is high in the 18th cycle after the start edge.
- R4: During the flush, scan_in_o carries 0, 0, 1, 1 (the word 0011, MSB first) followed by four 0s. During the load, it carries the stimulus MSB first. It is 0 in every other cycle.
- R5: In flush clocks 5 to 8, scan_out_o is compared with the flush word in entry order. Any mismatch sets result_o to 2'b11 (chain broken), and done_o follows right after the flush (9th cycle). No load or capture is applied.
- R6: The unloaded bits are reassembled so that resp_o equals the captured 4-bit counter value. The first unloaded bit becomes bit 3.
- R7: result_o is 2'b01 (pass) when resp_o equals the golden word and 2'b10 (fail) otherwise.
- R8: With inj_carry_sa0_i high, the carry into bit 0 is held at 0. Capture then leaves the count unchanged, so a golden word of stimulus+1 gives a fail.
- R9: done_o is a single-cycle pulse, with busy_o and scan_en_o low during it. busy_o is high from the cycle after the accepted start until done. result_o and resp_o hold their values until the next run completes.
- R10: A start request while busy is ignored. The stimulus and golden word are taken at the accepted start, so later changes on stim_i or gold_i have no effect on that run.
- R11: After reset: busy_o, done_o and scan_en_o are 0, result_o is 2'b00, resp_o is 0.
- R12: With inj_link_break_i high, the shift input of chain cell 2 is forced to 0, which breaks the chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, accepted when idle |
| stim_i | input | 4 | Stimulus word to load |
| gold_i | input | 4 | Expected captured word |
| inj_carry_sa0_i | input | 1 | Hold the increment carry at 0 |
| inj_link_break_i | input | 1 | Force one cell's shift input to 0 |
| busy_o | output | 1 | Test in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | 00 none, 01 pass, 10 fail, 11 chain broken |
| resp_o | output | 4 | Captured word read from the chain |
| scan_en_o | output | 1 | Scan-enable to the chain |
| scan_in_o | output | 1 | Serial chain input |
| scan_out_o | output | 1 | Serial chain output (bit 3) |

## Verification
The assertions assume that start_i is only a request: it may be held or pulsed at any time, and only the request seen while idle starts a run. They also assume that the fault injection inputs stay steady for the whole of a run, since a change midway would make the flush and the capture judge different chains. The bench sets the injection inputs and the words before it raises start. It changes stim_i and raises start_i again only during a run, and this is meant to check that they are ignored.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FLUSH, ST_LOAD, ST_CAPT, ST_UNLOAD, ST_DONE
  } seq_st_e;

  typedef enum logic [1:0] {
    RES_NONE   = 2'b00,
    RES_PASS   = 2'b01,
    RES_FAIL   = 2'b10,
    RES_BROKEN = 2'b11
  } res_e;
endpackage

// File: rtl/scan_cut.sv
// Counter under test: chain of mux-D cells with fault injection.
module scan_cut #(
  parameter int W          = 4,
  parameter int CARRY_NODE = 0,
  parameter int BREAK_IDX  = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         se_i,
  input  logic         si_i,
  input  logic         sa0_i,
  input  logic         brk_i,
  output logic         so_o,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;
  logic [W-1:0] cy;
  logic [W-1:0] nxt;
  logic [W-1:0] sh;

  for (genvar gi = 0; gi < W; gi++) begin : g_cell
    logic cy_raw;
    logic sh_raw;
    if (gi == 0) begin : g_head
      assign cy_raw = 1'b1;
      assign sh_raw = si_i;
    end else begin : g_body
      assign cy_raw = q[gi-1] & cy[gi-1];
      assign sh_raw = q[gi-1];
    end
    if (gi == CARRY_NODE) begin : g_sa
      assign cy[gi] = cy_raw & ~sa0_i;
    end else begin : g_nsa
      assign cy[gi] = cy_raw;
    end
    if (gi == BREAK_IDX) begin : g_brk
      assign sh[gi] = sh_raw & ~brk_i;
    end else begin : g_nbrk
      assign sh[gi] = sh_raw;
    end
    assign nxt[gi] = q[gi] ^ cy[gi];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   q[gi] <= 1'b0;
      else if (se_i) q[gi] <= sh[gi];
      else           q[gi] <= nxt[gi];
    end
  end

  assign q_o  = q;
  assign so_o = q[W-1];
endmodule

// File: rtl/scan_seq.sv
// Phase sequencer: flush, load, single capture, unload.
module scan_seq
  import scan_pkg::*;
#(
  parameter int           W         = 4,
  parameter int           CW        = 4,
  parameter logic [W-1:0] FLUSH_PAT = 4'b0011
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [W-1:0]  stim_i,
  input  logic          flush_ok_i,
  output seq_st_e       st_o,
  output logic [CW-1:0] cnt_o,
  output logic          take_o,
  output logic          last_o,
  output logic          se_o,
  output logic          si_o,
  output logic          busy_o,
  output logic          done_o
);
  localparam logic [CW-1:0] LAST_F = CW'(2*W-1);
  localparam logic [CW-1:0] LAST_W = CW'(W-1);

  seq_st_e       st_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  sreg_q;
  logic [W-1:0]  stim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sreg_q <= '0;
      stim_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= ST_FLUSH;
          cnt_q  <= '0;
          sreg_q <= FLUSH_PAT;
          stim_q <= stim_i;
        end
        ST_FLUSH: begin
          sreg_q <= {sreg_q[W-2:0], 1'b0};
          if (cnt_q == LAST_F) begin
            cnt_q <= '0;
            if (flush_ok_i) begin
              st_q   <= ST_LOAD;
              sreg_q <= stim_q;
            end else begin
              st_q <= ST_DONE;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_LOAD: begin
          sreg_q <= {sreg_q[W-2:0], 1'b0};
          if (cnt_q == LAST_W) begin
            cnt_q <= '0;
            st_q  <= ST_CAPT;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_CAPT: st_q <= ST_UNLOAD;
        ST_UNLOAD: begin
          if (cnt_q == LAST_W) begin
            cnt_q <= '0;
            st_q  <= ST_DONE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign st_o   = st_q;
  assign cnt_o  = cnt_q;
  assign take_o = (st_q == ST_IDLE) && start_i;
  assign last_o = ((st_q == ST_FLUSH) && (cnt_q == LAST_F)) ||
                  ((st_q == ST_UNLOAD) && (cnt_q == LAST_W));
  assign se_o   = (st_q == ST_FLUSH) || (st_q == ST_LOAD) || (st_q == ST_UNLOAD);
  assign si_o   = ((st_q == ST_FLUSH) || (st_q == ST_LOAD)) && sreg_q[W-1];
  assign busy_o = (st_q != ST_IDLE) && (st_q != ST_DONE);
  assign done_o = (st_q == ST_DONE);
endmodule

// File: rtl/scan_cmp.sv
// Flush checker, response reassembly and golden compare.
module scan_cmp
  import scan_pkg::*;
#(
  parameter int           W         = 4,
  parameter int           CW        = 4,
  parameter logic [W-1:0] FLUSH_PAT = 4'b0011
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  seq_st_e       st_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          take_i,
  input  logic          last_i,
  input  logic [W-1:0]  gold_i,
  input  logic          so_i,
  output logic          flush_ok_o,
  output res_e          result_o,
  output logic [W-1:0]  resp_o
);
  logic [W-1:0] exp_q;
  logic [W-1:0] gold_q;
  logic [W-1:0] cap_q;
  logic [W-1:0] word;
  logic         bad_q;
  logic         fl_win;
  logic         fl_mis;
  res_e         res_q;
  logic [W-1:0] resp_q;

  assign fl_win     = (st_i == ST_FLUSH) && (cnt_i >= CW'(W));
  assign fl_mis     = fl_win && (so_i != exp_q[W-1]);
  assign flush_ok_o = !(bad_q || fl_mis);
  assign word       = {cap_q[W-2:0], so_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_q  <= '0;
      gold_q <= '0;
      cap_q  <= '0;
      bad_q  <= 1'b0;
      res_q  <= RES_NONE;
      resp_q <= '0;
    end else begin
      if (take_i) begin
        exp_q  <= FLUSH_PAT;
        gold_q <= gold_i;
        bad_q  <= 1'b0;
      end else if (fl_win) begin
        exp_q <= {exp_q[W-2:0], 1'b0};
        bad_q <= bad_q | fl_mis;
      end
      if (st_i == ST_UNLOAD) cap_q <= word;
      if (last_i && (st_i == ST_FLUSH) && !flush_ok_o) res_q <= RES_BROKEN;
      if (last_i && (st_i == ST_UNLOAD)) begin
        resp_q <= word;
        res_q  <= (word == gold_q) ? RES_PASS : RES_FAIL;
      end
    end
  end

  assign result_o = res_q;
  assign resp_o   = resp_q;
endmodule

// File: rtl/scan_test_ctrl.sv
module scan_test_ctrl
  import scan_pkg::*;
#(
  parameter int           W          = 4,
  parameter logic [W-1:0] FLUSH_PAT  = 4'b0011,
  parameter int           CARRY_NODE = 0,
  parameter int           BREAK_IDX  = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] stim_i,
  input  logic [W-1:0] gold_i,
  input  logic         inj_carry_sa0_i,
  input  logic         inj_link_break_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [1:0]   result_o,
  output logic [W-1:0] resp_o,
  output logic         scan_en_o,
  output logic         scan_in_o,
  output logic         scan_out_o
);
  localparam int CW = $clog2(2*W) + 1;

  seq_st_e       st;
  logic [CW-1:0] cnt;
  logic          take;
  logic          last;
  logic          flush_ok;
  res_e          res;
  logic [W-1:0]  cut_q;

  scan_seq #(.W(W), .CW(CW), .FLUSH_PAT(FLUSH_PAT)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .stim_i     (stim_i),
    .flush_ok_i (flush_ok),
    .st_o       (st),
    .cnt_o      (cnt),
    .take_o     (take),
    .last_o     (last),
    .se_o       (scan_en_o),
    .si_o       (scan_in_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  scan_cut #(.W(W), .CARRY_NODE(CARRY_NODE), .BREAK_IDX(BREAK_IDX)) u_cut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .se_i   (scan_en_o),
    .si_i   (scan_in_o),
    .sa0_i  (inj_carry_sa0_i),
    .brk_i  (inj_link_break_i),
    .so_o   (scan_out_o),
    .q_o    (cut_q)
  );

  scan_cmp #(.W(W), .CW(CW), .FLUSH_PAT(FLUSH_PAT)) u_cmp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .st_i       (st),
    .cnt_i      (cnt),
    .take_i     (take),
    .last_i     (last),
    .gold_i     (gold_i),
    .so_i       (scan_out_o),
    .flush_ok_o (flush_ok),
    .result_o   (res),
    .resp_o     (resp_o)
  );

  assign result_o = res;
endmodule

// File: rtl/scan_test_ctrl_chk.sv
module scan_test_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       scan_en_o,
  input logic [1:0] result_o
);
  AST_ONE_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !scan_en_o) |=> (busy_o && scan_en_o)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !scan_en_o)); // R9
  AST_IDLE_SE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !done_o) |-> !scan_en_o); // R11
  AST_START_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !done_o && start_i) |=> busy_o); // R10
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_o ##1 !done_o) |-> $stable(result_o)); // R9
endmodule

bind scan_test_ctrl scan_test_ctrl_chk u_chk (.*);

// File: tb/scan_test_ctrl_tb.sv
`timescale 1ns/1ps
module scan_test_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] stim = '0;
  logic [3:0] gold = '0;
  logic       sa0 = 1'b0;
  logic       brk = 1'b0;
  logic       busy, done, se, si, so;
  logic [1:0] result;
  logic [3:0] resp;

  int n_vec = 0;
  int n_err = 0;
  logic se_rec [0:40];
  logic si_rec [0:40];

  always #4 clk = ~clk;

  scan_test_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stim_i(stim), .gold_i(gold),
    .inj_carry_sa0_i(sa0), .inj_link_break_i(brk), .busy_o(busy), .done_o(done),
    .result_o(result), .resp_o(resp), .scan_en_o(se), .scan_in_o(si), .scan_out_o(so)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run(input logic [3:0] s, input logic [3:0] g, input bit f_sa,
                     input bit f_brk, input bit poke);
    int didx, exp_d, se_bad, si_bad;
    logic [3:0] exp_resp;
    logic [1:0] exp_res;
    logic [3:0] pat;
    logic       e_se, e_si;
    @(negedge clk);
    stim = s; gold = g; sa0 = f_sa; brk = f_brk; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    didx = -1;
    for (int i = 0; i <= 40; i++) begin
      se_rec[i] = se;
      si_rec[i] = si;
      if (done) begin didx = i; break; end
      if (i == 1) check(busy == 1'b1, "R9 busy after start", int'(busy), 1);
      if (poke && i == 3) begin start = 1'b1; stim = ~s; gold = ~g; end
      if (poke && i == 4) start = 1'b0;
      @(negedge clk);
    end
    exp_d = f_brk ? 8 : 17;
    check(didx == exp_d, f_brk ? "R5 done index" : "R3 done index", didx, exp_d);
    pat = 4'b0011;
    se_bad = 0; si_bad = 0;
    for (int i = 0; i < exp_d && didx == exp_d; i++) begin
      e_se = (i != 12);
      if (i < 4)       e_si = pat[3-i];
      else if (i < 8)  e_si = 1'b0;
      else if (i < 12) e_si = s[11-i];
      else             e_si = 1'b0;
      if (se_rec[i] !== e_se) se_bad++;
      if (si_rec[i] !== e_si) si_bad++;
    end
    check(se_bad == 0, "R3 scan_en window", se_bad, 0);
    check(si_bad == 0, "R4 scan_in stream", si_bad, 0);
    check(se == 1'b0 && busy == 1'b0, "R9 quiet at done", int'({busy, se}), 0);
    exp_resp = f_sa ? s : s + 4'd1;
    if (f_brk) exp_res = 2'b11;
    else       exp_res = (exp_resp == g) ? 2'b01 : 2'b10;
    if (f_brk) check(result == exp_res, "R5 R12 broken code", result, exp_res);
    else if (f_sa) check(result == exp_res, "R8 stuck carry result", result, exp_res);
    else check(result == exp_res, poke ? "R10 R7 result" : "R7 result", result, exp_res);
    if (!f_brk) check(resp == exp_resp, f_sa ? "R8 resp" : "R6 R2 R1 resp", resp, exp_resp);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R9 done single pulse", int'({done, busy}), 0);
    check(result == exp_res, "R9 result held", result, exp_res);
    sa0 = 1'b0; brk = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && se == 0, "R11 reset controls", int'({busy, done, se}), 0);
    check(result == 2'b00 && resp == 4'd0, "R11 reset result", int'({result, resp}), 0);
    rst_n = 1'b1;
    for (int s = 0; s < 16; s++) run(4'(s), 4'(s + 1), 1'b0, 1'b0, 1'b0);
    for (int s = 0; s < 16; s++) run(4'(s), 4'(s + 3), 1'b0, 1'b0, 1'b0);
    for (int s = 0; s < 16; s++) run(4'(s), 4'(s + 1), 1'b1, 1'b0, 1'b0);
    for (int s = 0; s < 16; s++) run(4'(s), 4'(s + 1), 1'b0, 1'b1, 1'b0);
    run(4'b1110, 4'b1111, 1'b0, 1'b0, 1'b1);
    run(4'b0101, 4'b0110, 1'b0, 1'b0, 1'b1);
    run(4'b1110, 4'b1111, 1'b1, 1'b0, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule